// File: doc/BRIEF.md
# Bus Line Diagnosis and Safety Supervisor

This block supervises the receive side of a serial vehicle bus node. It watches the level of the currently selected receive line and three frame events from the frame decoder: a coherent frame, a frame addressed to this node, and a write to port A. From these it runs four tick-driven time-outs, all derived from one base period T (counted in timebase ticks). The stuck-dominant limit is T/16. The limit for missing bus traffic is T/4. The limit for traffic that never addresses this node is T. The limit with no access to the node at all is 4T.

The first three time-outs raise a one-cycle request to the line multiplexer to rotate to the next receive line, and then restart the diagnosis. A burst of seven edges on the line also counts as activity and restarts the diagnosis. The 4T time-out moves the node into SAFETY mode, which drives the interrupt pin high. SAFETY mode ends when port A is written.

The node may inhibit surveillance. While surveillance is inhibited, there are no rotations and SAFETY mode cannot be entered. In this mode the interrupt pin instead gives a short pulse after each frame addressed to the node.

Top module: `bus_line_supervisor`

## Requirements
- R1: After reset, `rotate_req`, `safe_mode` and `int_o` are all 0.
- R2: When `rx_dom` is 1 on BASE_TICKS/16 consecutive ticks, the short time-out fires. A cycle with `rx_dom` = 0 restarts that count from zero.
- R3: The medium time-out fires after BASE_TICKS/4 ticks in which neither `frame_ok` nor `frame_hit` was seen. Either pulse restarts that count.
- R4: The long time-out fires after BASE_TICKS ticks without a `frame_hit` pulse. `frame_ok` alone does not restart it.
- R5: Each short, medium or long time-out yields `rotate_req` = 1 for exactly one cycle, in the cycle after the edge that took the final tick. All three counts then restart from zero.
- R6: The seventh change of `rx_dom` (changes counted from reset, in groups of seven) restarts the short, medium and long counts. Six changes do not.
- R7: After 4×BASE_TICKS ticks without `frame_hit`, `safe_mode` and `int_o` become 1 in the cycle after the final tick. While `safe_mode` is 1, no `rotate_req` is raised.
- R8: A `porta_wr` pulse clears `safe_mode`, and `int_o` returns to 0 in the next cycle.
- R9: While `surv_off` is 1, neither `rotate_req` nor entry into `safe_mode` occurs.
- R10: When `surv_off` is 1, a `frame_hit` pulse makes `int_o` = 1 from the next cycle for PULSE_TICKS ticks. When `surv_off` is 0, `frame_hit` produces no pulse.
- R11: All counts advance only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase tick; counts advance only on it |
| rx_dom | input | 1 | Selected receive line is dominant (1) or recessive (0) |
| frame_ok | input | 1 | One-cycle pulse: a coherent frame was seen on the bus |
| frame_hit | input | 1 | One-cycle pulse: a frame read or wrote this node |
| porta_wr | input | 1 | One-cycle pulse: port A was written |
| surv_off | input | 1 | 1 = surveillance inhibited |
| rotate_req | output | 1 | One-cycle request to move to the next receive line |
| safe_mode | output | 1 | Node is in SAFETY mode |
| int_o | output | 1 | Interrupt pin |

## Verification
Every result of this block is one register away from its cause. A time-out fires combinationally on the edge that takes its final tick, so `rotate_req` or `safe_mode` reads 1 right after that edge. A `porta_wr` or `frame_hit` pulse shows on `int_o` right after the edge that sampled it. The bench therefore drives inputs just after a rising edge, advances exactly one edge per step, and samples the outputs one time unit later, numbering ticks from the first step after reset. With T = 64, each expectation is a closed form in the step index, for example a rotation when the step index is a multiple of 16, or SAFETY from step 256. Every step of each sweep is checked against that form.

// File: rtl/sup_pkg.sv
package sup_pkg;
   // number of time-outs that request a line rotation
   localparam int N_LINE_TO = 3;
   // index of each line time-out
   localparam int TO_STUCK = 0;
   localparam int TO_QUIET = 1;
   localparam int TO_DEAF  = 2;

   // limit in ticks of line time-out idx for base period base
   function automatic int to_limit(input int idx, input int base);
      case (idx)
         TO_STUCK: return base / 16;
         TO_QUIET: return base / 4;
         default:  return base;
      endcase
   endfunction
endpackage

// File: rtl/sup_tick_timer.sv
module sup_tick_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic evt_clr,
   input  logic restart,
   output logic fire
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("sup_tick_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign fire = tick && !evt_clr && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (evt_clr || restart || fire) cnt_q <= '0;
      else if (tick)                       cnt_q <= cnt_q + CW'(1);
   end

   // R11
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   // R11
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !evt_clr && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/sup_edge_watch.sv
module sup_edge_watch #(
   parameter int EDGES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_dom,
   output logic act_hit
);
   localparam int EW = $clog2(EDGES);
   localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

   if (EDGES < 2) begin : g_bad_edges
      $error("sup_edge_watch: EDGES must be at least 2");
   end

   logic          rx_q;
   logic [EW-1:0] ecnt_q;
   logic          edge_seen;

   assign edge_seen = rx_dom ^ rx_q;
   assign act_hit   = edge_seen && (ecnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q   <= 1'b0;
         ecnt_q <= '0;
      end else begin
         rx_q <= rx_dom;
         if (act_hit)        ecnt_q <= '0;
         else if (edge_seen) ecnt_q <= ecnt_q + EW'(1);
      end
   end

   // R6
   edge_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ecnt_q <= LAST);
endmodule

// File: rtl/sup_int_pulse.sv
module sup_int_pulse #(
   parameter int PULSE_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   output logic active
);
   localparam int PW = $clog2(PULSE_TICKS + 1);
   localparam logic [PW-1:0] FULL = PW'(PULSE_TICKS);

   if (PULSE_TICKS < 1) begin : g_bad_pulse
      $error("sup_int_pulse: PULSE_TICKS must be at least 1");
   end

   logic [PW-1:0] pcnt_q;

   assign active = (pcnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pcnt_q <= '0;
      else if (load)         pcnt_q <= FULL;
      else if (tick && active) pcnt_q <= pcnt_q - PW'(1);
   end

   // R10
   pulse_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= FULL);
endmodule

// File: rtl/bus_line_supervisor.sv
module bus_line_supervisor #(
   parameter int BASE_TICKS  = 64,
   parameter int ACT_EDGES   = 7,
   parameter int PULSE_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx_dom,
   input  logic frame_ok,
   input  logic frame_hit,
   input  logic porta_wr,
   input  logic surv_off,
   output logic rotate_req,
   output logic safe_mode,
   output logic int_o
);
   localparam int NL         = sup_pkg::N_LINE_TO;
   localparam int SAFE_LIMIT = 4 * BASE_TICKS;

   if ((BASE_TICKS % 16) != 0 || BASE_TICKS < 32) begin : g_bad_base
      $error("bus_line_supervisor: BASE_TICKS must be a multiple of 16, at least 32");
   end

   logic [NL-1:0] line_evt;
   logic [NL-1:0] line_fire;
   logic          act_hit;
   logic          restart;
   logic          slto_fire;
   logic          pulse_on;

   // clearing event of each line time-out
   assign line_evt[sup_pkg::TO_STUCK] = !rx_dom;
   assign line_evt[sup_pkg::TO_QUIET] = frame_ok || frame_hit;
   assign line_evt[sup_pkg::TO_DEAF]  = frame_hit;

   assign restart = (|line_fire) || act_hit;

   for (genvar gi = 0; gi < NL; gi++) begin : g_line
      sup_tick_timer #(
         .LIMIT(sup_pkg::to_limit(gi, BASE_TICKS))
      ) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .evt_clr (line_evt[gi]),
         .restart (restart),
         .fire    (line_fire[gi])
      );
   end

   sup_tick_timer #(
      .LIMIT(SAFE_LIMIT)
   ) u_safe_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .evt_clr (frame_hit),
      .restart (1'b0),
      .fire    (slto_fire)
   );

   sup_edge_watch #(
      .EDGES(ACT_EDGES)
   ) u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_dom  (rx_dom),
      .act_hit (act_hit)
   );

   sup_int_pulse #(
      .PULSE_TICKS(PULSE_TICKS)
   ) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .load   (frame_hit && surv_off),
      .active (pulse_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rotate_req <= 1'b0;
         safe_mode  <= 1'b0;
      end else begin
         rotate_req <= (|line_fire) && !safe_mode && !surv_off;
         if (porta_wr)                      safe_mode <= 1'b0;
         else if (slto_fire && !surv_off)   safe_mode <= 1'b1;
      end
   end

   assign int_o = safe_mode || pulse_on;

   // R5
   rot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rotate_req |=> !rotate_req);
   // R7
   safe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(safe_mode) |-> $past(slto_fire));
   // R8
   safe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(safe_mode) |-> $past(porta_wr));
   // R9
   no_safe_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (surv_off && !safe_mode) |=> !safe_mode);
endmodule

// File: tb/bus_line_supervisor_tb_top.sv
module bus_line_supervisor_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int T  = 64;
   localparam int P  = 3;
   localparam int WATCHDOG_CYCLES = 50000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, rx_dom = 1'b0, frame_ok = 1'b0, frame_hit = 1'b0;
   logic porta_wr = 1'b0, surv_off = 1'b0;
   logic rotate_req, safe_mode, int_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_line_supervisor #(.BASE_TICKS(T), .ACT_EDGES(7), .PULSE_TICKS(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_dom(rx_dom),
      .frame_ok(frame_ok), .frame_hit(frame_hit), .porta_wr(porta_wr),
      .surv_off(surv_off), .rotate_req(rotate_req), .safe_mode(safe_mode),
      .int_o(int_o));

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick = 0; rx_dom = 0; frame_ok = 0; frame_hit = 0; porta_wr = 0; surv_off = 0;
      step(); step();
      rst_n = 1'b1;
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG_CYCLES && !done; c++) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      check("R1", "rotate_req", rotate_req, 1'b0);
      check("R1", "safe_mode", safe_mode, 1'b0);
      check("R1", "int_o", int_o, 1'b0);

      // R3 R5 R7: quiet bus, rotation every T/4, SAFETY at 4T
      tick = 1;
      for (int k = 1; k <= 275; k++) begin
         step();
         check("R3_R7", "rotate_req", rotate_req, (k % 16 == 0) && (k <= 256));
         check("R7", "safe_mode", safe_mode, k >= 256);
         check("R7", "int_o", int_o, k >= 256);
      end
      porta_wr = 1; step(); porta_wr = 0;
      check("R8", "safe_mode", safe_mode, 1'b0);
      check("R8", "int_o", int_o, 1'b0);

      // R2: stuck dominant, cleared by a recessive cycle
      do_reset();
      tick = 1;
      for (int k = 1; k <= 11; k++) begin
         rx_dom = (k != 3);
         step();
         check("R2", "rotate_req", rotate_req, (k == 7) || (k == 11));
      end

      // R4: coherent frames but none addressed
      do_reset();
      tick = 1;
      for (int k = 1; k <= 70; k++) begin
         frame_ok = (k % 8 == 0);
         step();
         check("R4", "rotate_req", rotate_req, k == 64);
      end
      frame_ok = 0;

      // R3 R4 R7: addressed frames keep everything quiet
      do_reset();
      tick = 1;
      for (int k = 1; k <= 300; k++) begin
         frame_ok  = (k % 8 == 0);
         frame_hit = (k % 50 == 0);
         step();
         check("R4", "rotate_req", rotate_req, 1'b0);
         check("R7", "safe_mode", safe_mode, 1'b0);
      end
      frame_ok = 0; frame_hit = 0;

      // R6: continuous toggling prevents rotation
      do_reset();
      tick = 1;
      for (int k = 1; k <= 60; k++) begin
         rx_dom = (k % 2 == 1);
         step();
         check("R6", "rotate_req toggling", rotate_req, 1'b0);
      end

      // R6: six edges do not restart
      do_reset();
      tick = 1;
      for (int k = 1; k <= 20; k++) begin
         rx_dom = (k <= 6) ? (k % 2 == 1) : 1'b0;
         step();
         check("R6", "rotate_req six edges", rotate_req, k == 16);
      end

      // R6: seven edges restart at step 7
      do_reset();
      tick = 1;
      for (int k = 1; k <= 26; k++) begin
         rx_dom = (k <= 7) ? (k % 2 == 1) : 1'b0;
         step();
         check("R6", "rotate_req seven edges", rotate_req, k == 23);
      end

      // R11: ticks only on even steps
      do_reset();
      for (int k = 1; k <= 34; k++) begin
         tick = (k % 2 == 0);
         step();
         check("R11", "rotate_req half rate", rotate_req, k == 32);
      end

      // R9: surveillance inhibited, quiet bus
      do_reset();
      tick = 1; surv_off = 1;
      for (int k = 1; k <= 270; k++) begin
         step();
         check("R9", "rotate_req", rotate_req, 1'b0);
         check("R9", "safe_mode", safe_mode, 1'b0);
      end

      // R10: interrupt pulse on addressed frame while inhibited
      frame_hit = 1; step(); frame_hit = 0;
      check("R10", "int_o pulse t0", int_o, 1'b1);
      step(); check("R10", "int_o pulse t1", int_o, 1'b1);
      step(); check("R10", "int_o pulse t2", int_o, 1'b1);
      step(); check("R10", "int_o pulse end", int_o, 1'b0);

      // R10: no pulse while surveillance active
      surv_off = 0;
      frame_hit = 1; step(); frame_hit = 0;
      check("R10", "int_o no pulse", int_o, 1'b0);
      step(); check("R10", "int_o no pulse later", int_o, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule